// File: doc/BRIEF.md
# Serial Control Port with Register Bank

This block lets an external serial master read and write a bank of 8-bit configuration registers through a four-wire port. The port has an active-low select, a clock from the master, a data input and a data output. The registers themselves are also reachable from inside the chip through a parallel port. That port has one write path and one combinational read path. Register 0 through `NUM_REGS-1` are implemented. The rest of the 7-bit address space reads as zero and ignores writes.

Every transaction is 16 bits long and is shifted most significant bit first. The first bit is the direction: 0 is a write and 1 is a read. The next seven bits are the register address, and the last eight bits are data. A write only takes effect once all 16 bits have arrived. On a read, the register value is captured as soon as the address is complete, and it is shifted out on the data output during the last eight bit times. Whenever the select goes high, the port drops back to idle, even if the frame was not finished.

The serial pins are brought into the system clock domain through synchronizers. Edges of the serial clock are detected there. Input bits are taken on rising serial-clock edges, and output bits change after falling edges.

Top module: `sctl_port`

## Requirements
- R1: A frame whose first bit is 1 is a read and never changes any register. A frame whose first bit is 0 is a write.
- R2: Bits 2 to 8 of a frame form the 7-bit register address, most significant bit first.
- R3: In a write frame, bits 9 to 16 are the data, most significant bit first. The data is stored in the addressed register once the 16th rising serial-clock edge has been taken with select still low.
- R4: In a read frame, the addressed register's value appears on `spi_sdo`, most significant bit first. Each bit changes after a falling serial-clock edge, so the master takes bits 9 to 16 on its rising edges. `spi_sdo_oe` is 1 during this data phase.
- R5: The data-input bits of a read frame are ignored, and the register keeps its value.
- R6: While select is high, `spi_sdo_oe` and `spi_sdo` are 0, and serial-clock edges have no effect on any register.
- R7: A rising select aborts the frame in progress. A write frame with fewer than 16 bits leaves every register unchanged. The next frame is decoded from its own first bit.
- R8: Addresses at or above `NUM_REGS` read as 0x00 on both ports. Writes to them change no register.
- R9: After reset, every register is 0x00 and `spi_sdo_oe` is 0.
- R10: A parallel-port write (`host_we`=1) stores `host_wdata` at `host_addr` on the next clock. `host_rdata` shows the register at `host_raddr` combinationally. A later serial read returns the value written through the parallel port.
- R11: Serial-clock edges after the 16th in one select period are ignored. A write is stored once, with the data from bits 9 to 16.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Active-low select from the serial master |
| spi_sck | input | 1 | Serial clock from the master |
| spi_sdi | input | 1 | Serial data into the port |
| spi_sdo | output | 1 | Serial read data; held 0 when not enabled |
| spi_sdo_oe | output | 1 | Enable for the serial data output pad |
| host_we | input | 1 | Parallel-port write strobe |
| host_addr | input | 7 | Parallel-port write address |
| host_wdata | input | 8 | Parallel-port write data |
| host_raddr | input | 7 | Parallel-port read address |
| host_rdata | output | 8 | Parallel-port read data |

## Verification
The assertions assume that the serial clock, select and data inputs change slowly relative to `clk`. Each serial-clock half period must be several system clocks long, so that the two-flop synchronizers deliver one clean edge event per level change and the data bit is settled when the rising edge is detected. The bench keeps within this assumption. It changes data only while the serial clock is low, holds every serial half period for six system clocks, and moves select only while the serial clock is low. Random frames mix reads and writes, addresses inside and outside the bank, and random data. Directed cases cover aborted frames, over-long frames, clocks with select high and parallel-port writes.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  localparam int DIR_W   = 1;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int HDR_W   = DIR_W + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [DATA_W-1:0]  data_t;
  typedef logic [HDR_W-1:0]   hdr_t;
  typedef logic [FRAME_W-1:0] frame_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_WDATA,
    PH_RDATA,
    PH_DONE
  } phase_e;

  // direction bit is the oldest bit of the header
  function automatic logic hdr_is_read(hdr_t h);
    return h[HDR_W-1];
  endfunction

  function automatic addr_t hdr_addr(hdr_t h);
    return h[ADDR_W-1:0];
  endfunction

  function automatic hdr_t frame_hdr(frame_t f);
    return f[FRAME_W-1 -: HDR_W];
  endfunction

  function automatic data_t frame_data(frame_t f);
    return f[DATA_W-1:0];
  endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], async_in[g]};
    end

    assign sync_out[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/sctl_frame.sv
module sctl_frame
  import sctl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   csn,
  input  logic   csn_rise,
  input  logic   sck_rise,
  input  logic   sck_fall,
  input  logic   sdi,
  output addr_t  rd_addr,
  input  data_t  rd_data,
  output logic   wr_commit,
  output addr_t  wr_addr,
  output data_t  wr_data,
  output logic   rd_load,
  output logic   sdo,
  output logic   sdo_oe
);

  logic [CNT_W-1:0] bit_cnt;
  frame_t           shreg;
  frame_t           next_word;
  phase_e           phase;
  data_t            out_sr;
  logic             sdo_q;
  logic             rd_frame;
  logic             active;
  logic             take_bit;
  logic             hdr_done;
  logic             frame_done;
  hdr_t             hdr_now;

  assign active     = ~csn;
  assign take_bit   = active & sck_rise & (bit_cnt < CNT_W'(FRAME_W));
  assign next_word  = {shreg[FRAME_W-2:0], sdi};
  assign hdr_done   = take_bit & (bit_cnt == CNT_W'(HDR_W - 1));
  assign frame_done = take_bit & (bit_cnt == CNT_W'(FRAME_W - 1));
  assign hdr_now    = next_word[HDR_W-1:0];

  assign rd_addr    = hdr_addr(hdr_now);
  assign rd_load    = hdr_done & hdr_is_read(hdr_now);
  assign wr_commit  = frame_done & (phase == PH_WDATA);
  assign wr_addr    = hdr_addr(frame_hdr(next_word));
  assign wr_data    = frame_data(next_word);

  assign sdo_oe     = rd_frame & active;
  assign sdo        = sdo_oe & sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      phase    <= PH_IDLE;
      out_sr   <= '0;
      sdo_q    <= 1'b0;
      rd_frame <= 1'b0;
    end else if (csn || csn_rise) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      phase    <= PH_IDLE;
      out_sr   <= '0;
      sdo_q    <= 1'b0;
      rd_frame <= 1'b0;
    end else begin
      if (take_bit) begin
        shreg   <= next_word;
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (phase == PH_IDLE) phase <= PH_HDR;
      if (hdr_done) phase <= hdr_is_read(hdr_now) ? PH_RDATA : PH_WDATA;
      if (frame_done) phase <= PH_DONE;
      if (rd_load) begin
        out_sr   <= rd_data;
        rd_frame <= 1'b1;
      end
      if (sck_fall && phase == PH_RDATA) begin
        sdo_q  <= out_sr[DATA_W-1];
        out_sr <= {out_sr[DATA_W-2:0], 1'b0};
      end
    end
  end

  // R7
  abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_rise |=> (bit_cnt == '0) && (phase == PH_IDLE) && !sdo_oe);

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W));

  // R3
  commit_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> (phase == PH_DONE) && (bit_cnt == CNT_W'(FRAME_W)));

  // R4
  rd_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> sdo_oe && (phase == PH_RDATA));

endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile
  import sctl_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  s_we,
  input  addr_t s_waddr,
  input  data_t s_wdata,
  input  addr_t s_raddr,
  output data_t s_rdata,
  input  logic  h_we,
  input  addr_t h_waddr,
  input  data_t h_wdata,
  input  addr_t h_raddr,
  output data_t h_rdata
);

  localparam int FLAT_W = NUM_REGS * DATA_W;

  data_t             regs [NUM_REGS];
  logic [FLAT_W-1:0] regs_flat;

  function automatic logic in_range(addr_t a);
    return int'(a) < NUM_REGS;
  endfunction

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   regs[g] <= '0;
      else if (h_we && h_waddr == ADDR_W'(g))       regs[g] <= h_wdata;
      else if (s_we && s_waddr == ADDR_W'(g))       regs[g] <= s_wdata;
    end
    assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
  end

  always_comb begin
    s_rdata = '0;
    h_rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (s_raddr == ADDR_W'(i)) s_rdata = regs[i];
      if (h_raddr == ADDR_W'(i)) h_rdata = regs[i];
    end
  end

  // R8
  oob_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_we && !in_range(s_waddr) && !h_we) |=> $stable(regs_flat));

  // R1
  idle_bank_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_we && !h_we) |=> $stable(regs_flat));

endmodule

// File: rtl/sctl_port.sv
module sctl_port
  import sctl_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_csn,
  input  logic       spi_sck,
  input  logic       spi_sdi,
  output logic       spi_sdo,
  output logic       spi_sdo_oe,
  input  logic       host_we,
  input  logic [6:0] host_addr,
  input  logic [7:0] host_wdata,
  input  logic [6:0] host_raddr,
  output logic [7:0] host_rdata
);

  logic [2:0] pins_s;
  logic       csn_s, sck_s, sdi_s;
  logic       csn_d, sck_d;
  logic       csn_rise, sck_rise, sck_fall;
  logic       wr_commit, rd_load;
  addr_t      wr_addr, rd_addr;
  data_t      wr_data, rd_data;

  sctl_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({spi_csn, spi_sck, spi_sdi}),
    .sync_out (pins_s)
  );

  assign {csn_s, sck_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_d <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      csn_d <= csn_s;
      sck_d <= sck_s;
    end
  end

  assign csn_rise = csn_s & ~csn_d;
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;

  sctl_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .csn       (csn_s),
    .csn_rise  (csn_rise),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .sdi       (sdi_s),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .wr_commit (wr_commit),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_load   (rd_load),
    .sdo       (spi_sdo),
    .sdo_oe    (spi_sdo_oe)
  );

  sctl_regfile #(
    .NUM_REGS (NUM_REGS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_we    (wr_commit),
    .s_waddr (wr_addr),
    .s_wdata (wr_data),
    .s_raddr (rd_addr),
    .s_rdata (rd_data),
    .h_we    (host_we),
    .h_waddr (host_addr),
    .h_wdata (host_wdata),
    .h_raddr (host_raddr),
    .h_rdata (host_rdata)
  );

  // R6
  idle_output_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |-> (!spi_sdo_oe && !spi_sdo));

  // R1
  read_never_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |-> !wr_commit);

endmodule

// File: tb/sctl_port_bench.sv
module sctl_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 6;
  localparam int NREGS      = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       spi_csn, spi_sck, spi_sdi;
  logic       spi_sdo, spi_sdo_oe;
  logic       host_we;
  logic [6:0] host_addr, host_raddr;
  logic [7:0] host_wdata, host_rdata;

  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;
  logic [7:0] model [NREGS];

  always #(CLK_PERIOD/2) clk = ~clk;

  sctl_port #(.NUM_REGS(NREGS)) u_sctl_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_csn    (spi_csn),
    .spi_sck    (spi_sck),
    .spi_sdi    (spi_sdi),
    .spi_sdo    (spi_sdo),
    .spi_sdo_oe (spi_sdo_oe),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_raddr (host_raddr),
    .host_rdata (host_rdata)
  );

  function automatic logic [7:0] exp_read(logic [6:0] a);
    return (int'(a) < NREGS) ? model[a] : 8'h00;
  endfunction

  function automatic logic [15:0] make_frame(bit rd, logic [6:0] a, logic [7:0] d);
    return {rd, a, d};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // one select period with nbits serial clocks; returns the byte seen on sdo
  task automatic spi_xfer(bit rd, logic [6:0] a, logic [7:0] d, int nbits,
                          output logic [7:0] rdback);
    logic [15:0] fr;
    fr = make_frame(rd, a, d);
    rdback = '0;
    @(negedge clk);
    spi_csn = 1'b0;
    wait_clk(HALF_SCK);
    for (int i = 0; i < nbits; i++) begin
      if (i < 16 && !(rd && i >= 8)) spi_sdi = fr[15-i];
      else                           spi_sdi = 1'($urandom);
      wait_clk(HALF_SCK);
      if (rd && i >= 8 && i < 16) begin
        rdback[15-i] = spi_sdo;
        chk("R4 oe", 32'(spi_sdo_oe), 32'd1);
      end
      spi_sck = 1'b1;
      wait_clk(HALF_SCK);
      spi_sck = 1'b0;
    end
    wait_clk(HALF_SCK);
    spi_csn = 1'b1;
    wait_clk(HALF_SCK);
    if (!rd && nbits >= 16 && int'(a) < NREGS) model[a] = d;
  endtask

  task automatic host_write(logic [6:0] a, logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    if (int'(a) < NREGS) model[a] = d;
  endtask

  task automatic host_check(string req, logic [6:0] a);
    @(negedge clk);
    host_raddr = a;
    #1;
    chk(req, 32'(host_rdata), 32'(exp_read(a)));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] rb;
    logic [31:0] seed;
    seed = $urandom(32'h1DEA5);
    for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
    rst_n = 1'b0; spi_csn = 1'b1; spi_sck = 1'b0; spi_sdi = 1'b0;
    host_we = 1'b0; host_addr = '0; host_wdata = '0; host_raddr = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);

    // R9 reset state
    chk("R9 oe", 32'(spi_sdo_oe), 32'd0);
    host_check("R9 reg0", 7'd0);
    host_check("R9 reg15", 7'd15);

    // R2 R3 write then parallel read
    spi_xfer(1'b0, 7'd3, 8'hA5, 16, rb);
    host_check("R3 write A5", 7'd3);
    spi_xfer(1'b0, 7'd12, 8'h3C, 16, rb);
    host_check("R2 addr 12", 7'd12);
    host_check("R2 addr 3 untouched", 7'd3);

    // R4 serial read
    spi_xfer(1'b1, 7'd3, 8'h00, 16, rb);
    chk("R4 read A5", 32'(rb), 32'hA5);

    // R5 R1 read with noisy data bits leaves register alone
    spi_xfer(1'b1, 7'd12, 8'hFF, 16, rb);
    chk("R1 read 3C", 32'(rb), 32'h3C);
    host_check("R5 reg12 kept", 7'd12);

    // R7 abort a write after 15 bits, then a fresh frame
    spi_xfer(1'b0, 7'd3, 8'h11, 15, rb);
    host_check("R7 aborted write", 7'd3);
    spi_xfer(1'b1, 7'd5, 8'h00, 10, rb);
    spi_xfer(1'b0, 7'd5, 8'h77, 16, rb);
    host_check("R7 next frame", 7'd5);

    // R8 unimplemented address
    spi_xfer(1'b0, 7'h53, 8'hFF, 16, rb);
    host_check("R8 oob host", 7'h53);
    host_check("R8 no alias", 7'h03);
    spi_xfer(1'b1, 7'h53, 8'h00, 16, rb);
    chk("R8 oob serial", 32'(rb), 32'h00);

    // R11 over-long frame
    spi_xfer(1'b0, 7'd7, 8'hC3, 21, rb);
    host_check("R11 extra clocks", 7'd7);

    // R6 clocks with select high
    for (int i = 0; i < 16; i++) begin
      spi_sdi = make_frame(1'b0, 7'd3, 8'h00) >> (15 - i);
      wait_clk(HALF_SCK);
      chk("R6 oe idle", 32'({spi_sdo_oe, spi_sdo}), 32'd0);
      spi_sck = 1'b1;
      wait_clk(HALF_SCK);
      spi_sck = 1'b0;
    end
    host_check("R6 reg3 kept", 7'd3);

    // R10 parallel write visible on serial read
    host_write(7'd9, 8'h5A);
    host_check("R10 host read", 7'd9);
    spi_xfer(1'b1, 7'd9, 8'h00, 16, rb);
    chk("R10 serial sees host", 32'(rb), 32'h5A);
    host_write(7'h40, 8'hEE);
    host_check("R10 R8 host oob", 7'h40);

    // random frames
    for (int k = 0; k < 40; k++) begin
      logic [6:0] a;
      logic [7:0] d;
      bit rd;
      a  = 7'($urandom_range(0, NREGS + 3));
      d  = 8'($urandom);
      rd = 1'($urandom);
      if (rd) begin
        spi_xfer(1'b1, a, d, 16, rb);
        chk("R4 random read", 32'(rb), 32'(exp_read(a)));
      end else begin
        spi_xfer(1'b0, a, d, 16, rb);
        host_check("R3 random write", a);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule